// File: doc/BRIEF.md
# GPIO Pad Reset-Domain Register

This block holds the configuration word of one general-purpose I/O pad and the lock bit that guards part of that word. A two-bit reset-configuration code in the top two bits of the word chooses which platform reset events put the word back to its default value. A build-time parameter picks the pad family: primary-well or deep-sleep-well. The family changes which events count for each code.

Six single-cycle event pulses arrive from the power sequencer: warm reset, cold reset, sleep-state entry (S3/S4/S5), global reset, deep-sleep entry and full power loss (G3). The lock bit has its own set strobe. It is cleared only by the fixed power-good domain, whatever code the word holds. This means the word can fall back to its default while it is still locked. A mismatch output flags that situation so that firmware or a monitor can see it.

Top module: `pad_rst_domain_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads the parameter `DEFAULT` into `cfg_q`, clears `lock_q` and clears `rsv_q`. The new values are visible after that edge.
- R2: With the lock clear, a write (`wr_en` high) stores `wr_data` into `cfg_q` at the next edge. The one exception is the R6 substitution.
- R3: The reset-configuration code sits in `cfg_q[CFG_W-1:CFG_W-2]`. Code 00 (power-good) returns `cfg_q` to `DEFAULT` on deep-sleep entry or G3 in a primary-well pad. In a deep-sleep-well pad it does so on G3 only.
- R4: Code 01 (deep) returns `cfg_q` to `DEFAULT` on warm, cold, global, deep-sleep and G3 events. A sleep-state entry pulse leaves it unchanged.
- R5: Code 10 (host) returns `cfg_q` to `DEFAULT` on any of the six events.
- R6: Code 11 is reserved in a primary-well pad. A write carrying 11 stores 00 in the code field and sets `rsv_q`. The next accepted write or the next reset of the word clears `rsv_q`. In a deep-sleep-well pad, code 11 is kept as written, returns `cfg_q` to `DEFAULT` on deep-sleep entry or G3 only, and never sets `rsv_q`.
- R7: `lock_set` sets `lock_q` at the next edge. Only `rst` or a power-good event for the family clears it: deep-sleep entry or G3 for primary-well, G3 for deep-sleep-well. Such a clearing event beats `lock_set` in the same cycle.
- R8: While `lock_q` is high, a write leaves the bits set in `LOCK_MASK` unchanged and updates the other bits. The default mask covers bits 31:30 and 7:0.
- R9: When a write and an event that resets the word fall in the same cycle, `cfg_q` takes `DEFAULT`.
- R10: `mismatch` is high exactly when `lock_q` is high and the code field of `cfg_q` is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | CFG_W | Configuration write data |
| lock_set | input | 1 | Strobe that sets the lock bit |
| ev_warm | input | 1 | Warm reset event pulse |
| ev_cold | input | 1 | Cold reset event pulse |
| ev_sx | input | 1 | Sleep-state (S3/S4/S5) entry pulse |
| ev_global | input | 1 | Global reset event pulse |
| ev_deep | input | 1 | Deep-sleep entry pulse |
| ev_g3 | input | 1 | Full power loss (G3) pulse |
| cfg_q | output | CFG_W | Current configuration word |
| lock_q | output | 1 | Lock bit |
| rsv_q | output | 1 | Reserved code was written (primary-well only) |
| mismatch | output | 1 | Lock is set while the code is not power-good |

## Verification
Two pairs of functions can fall in the same cycle. A configuration write can coincide with an event that resets the word. A lock-set strobe can coincide with a power-good clearing event. The bench drives both pairs in one cycle. In each case it expects the reset side to win: the word shows `DEFAULT` and the lock stays clear. A primary-well instance and a deep-sleep-well instance get the same stimulus, so one run compares both reset matrices against a reference model for each family.

// File: rtl/pad_rst_pkg.sv
package pad_rst_pkg;

  typedef enum logic [1:0] {
    RC_PWRGOOD = 2'b00,
    RC_DEEP    = 2'b01,
    RC_HOST    = 2'b10,
    RC_RESUME  = 2'b11
  } rstcfg_e;

  typedef enum logic {
    FAM_PRIMARY = 1'b0,
    FAM_DSW     = 1'b1
  } pad_family_e;

  typedef struct packed {
    logic warm;
    logic cold;
    logic sx;
    logic glob;
    logic deep;
    logic g3;
  } pad_evt_t;

  // Does this event set return a word with code 'enc' to default?
  function automatic logic evt_resets(pad_family_e fam, logic [1:0] enc, pad_evt_t ev);
    logic hit;
    case (enc)
      RC_PWRGOOD: hit = (fam == FAM_PRIMARY) ? (ev.deep | ev.g3) : ev.g3;
      RC_DEEP:    hit = ev.warm | ev.cold | ev.glob | ev.deep | ev.g3;
      RC_HOST:    hit = |ev;
      default:    hit = ev.deep | ev.g3; // primary: aliased to power-good; dsw: resume
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pad_rst_decode.sv
module pad_rst_decode
  import pad_rst_pkg::*;
#(
  parameter pad_family_e FAMILY = FAM_PRIMARY
) (
  input  pad_evt_t   ev,
  input  logic [1:0] cfg_enc,
  output logic       cfg_hit,
  output logic       lock_hit
);
  logic [1:0] enc_eff;

  generate
    if (FAMILY == FAM_PRIMARY) begin : g_prim
      assign enc_eff = (cfg_enc == RC_RESUME) ? RC_PWRGOOD : cfg_enc;
    end else begin : g_dsw
      assign enc_eff = cfg_enc;
    end
  endgenerate

  always_comb begin
    cfg_hit  = evt_resets(FAMILY, enc_eff, ev);
    lock_hit = evt_resets(FAMILY, RC_PWRGOOD, ev);
  end
endmodule

// File: rtl/pad_cfg_store.sv
module pad_cfg_store
  import pad_rst_pkg::*;
#(
  parameter int           CFG_W     = 32,
  parameter logic [CFG_W-1:0] DEFAULT   = 32'h4000_0000,
  parameter logic [CFG_W-1:0] LOCK_MASK = 32'hC000_00FF,
  parameter pad_family_e  FAMILY    = FAM_PRIMARY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             locked,
  output logic [CFG_W-1:0] cfg_q,
  output logic             rsv_q
);
  localparam int FLD_HI = CFG_W - 1;
  localparam int FLD_LO = CFG_W - 2;

  logic [CFG_W-1:0] merged;
  logic [CFG_W-1:0] wr_val;
  logic             rsv_wr;

  always_comb begin
    merged = locked ? ((cfg_q & LOCK_MASK) | (wr_data & ~LOCK_MASK)) : wr_data;
    rsv_wr = (FAMILY == FAM_PRIMARY) && (merged[FLD_HI:FLD_LO] == RC_RESUME);
    wr_val = merged;
    if (rsv_wr) wr_val[FLD_HI:FLD_LO] = RC_PWRGOOD;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cfg_q <= DEFAULT;
      rsv_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= wr_val;
      rsv_q <= rsv_wr;
    end
  end
endmodule

// File: rtl/pad_lock_reg.sv
module pad_lock_reg (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) lock_q <= 1'b0;
    else if (set)   lock_q <= 1'b1;
  end
endmodule

// File: rtl/pad_rst_domain_reg.sv
module pad_rst_domain_reg
  import pad_rst_pkg::*;
#(
  parameter int               CFG_W     = 32,
  parameter logic [CFG_W-1:0] DEFAULT   = 32'h4000_0000,
  parameter logic [CFG_W-1:0] LOCK_MASK = 32'hC000_00FF,
  parameter pad_family_e      FAMILY    = FAM_PRIMARY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lock_set,
  input  logic             ev_warm,
  input  logic             ev_cold,
  input  logic             ev_sx,
  input  logic             ev_global,
  input  logic             ev_deep,
  input  logic             ev_g3,
  output logic [CFG_W-1:0] cfg_q,
  output logic             lock_q,
  output logic             rsv_q,
  output logic             mismatch
);
  localparam int FLD_HI = CFG_W - 1;
  localparam int FLD_LO = CFG_W - 2;

  pad_evt_t ev;
  logic     cfg_hit;
  logic     lock_hit;

  assign ev = '{warm: ev_warm, cold: ev_cold, sx: ev_sx,
                glob: ev_global, deep: ev_deep, g3: ev_g3};

  pad_rst_decode #(.FAMILY(FAMILY)) u_dec (
    .ev       (ev),
    .cfg_enc  (cfg_q[FLD_HI:FLD_LO]),
    .cfg_hit  (cfg_hit),
    .lock_hit (lock_hit)
  );

  pad_cfg_store #(
    .CFG_W(CFG_W), .DEFAULT(DEFAULT), .LOCK_MASK(LOCK_MASK), .FAMILY(FAMILY)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (cfg_hit),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .locked  (lock_q),
    .cfg_q   (cfg_q),
    .rsv_q   (rsv_q)
  );

  pad_lock_reg u_lock (
    .clk    (clk),
    .rst    (rst),
    .clr    (lock_hit),
    .set    (lock_set),
    .lock_q (lock_q)
  );

  // decode of flops only
  assign mismatch = lock_q && (cfg_q[FLD_HI:FLD_LO] != RC_PWRGOOD);
endmodule

// File: rtl/pad_rst_domain_chk.sv
module pad_rst_domain_chk
  import pad_rst_pkg::*;
#(
  parameter int               CFG_W     = 32,
  parameter logic [CFG_W-1:0] DEFAULT   = 32'h4000_0000,
  parameter logic [CFG_W-1:0] LOCK_MASK = 32'hC000_00FF,
  parameter pad_family_e      FAMILY    = FAM_PRIMARY
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             lock_set,
  input logic             ev_warm,
  input logic             ev_cold,
  input logic             ev_sx,
  input logic             ev_global,
  input logic             ev_deep,
  input logic             ev_g3,
  input logic [CFG_W-1:0] cfg_q,
  input logic             lock_q,
  input logic             rsv_q,
  input logic             mismatch
);
  logic [1:0] fld;
  logic       any_ev;
  assign fld    = cfg_q[CFG_W-1 -: 2];
  assign any_ev = ev_warm | ev_cold | ev_sx | ev_global | ev_deep | ev_g3;

  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (cfg_q == DEFAULT) && !lock_q && !rsv_q); // R1

  AST_SX_KEEPS_DEEP: assert property (@(posedge clk) disable iff (rst)
    (fld == 2'b01) && ev_sx && !wr_en && !ev_warm && !ev_cold && !ev_global
      && !ev_deep && !ev_g3 |=> $stable(cfg_q)); // R4

  AST_HOST_WARM: assert property (@(posedge clk) disable iff (rst)
    (fld == 2'b10) && ev_warm |=> cfg_q == DEFAULT); // R5

  AST_PRIM_NO_RSV_CODE: assert property (@(posedge clk) disable iff (rst)
    (FAMILY == FAM_PRIMARY) |-> fld != 2'b11); // R6

  AST_RSV_PRIM_ONLY: assert property (@(posedge clk) disable iff (rst)
    rsv_q |-> (FAMILY == FAM_PRIMARY)); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    lock_q && !ev_deep && !ev_g3 |=> lock_q); // R7

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (rst)
    lock_set && !ev_deep && !ev_g3 |=> lock_q); // R7

  AST_LOCKED_BITS: assert property (@(posedge clk) disable iff (rst)
    lock_q && wr_en && !any_ev |=> ((cfg_q ^ $past(cfg_q)) & LOCK_MASK) == '0); // R8

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en && ev_g3 |=> cfg_q == DEFAULT); // R9

  AST_MISMATCH_LOCK: assert property (@(posedge clk) disable iff (rst)
    mismatch |-> lock_q); // R10
endmodule

bind pad_rst_domain_reg pad_rst_domain_chk #(
  .CFG_W(CFG_W), .DEFAULT(DEFAULT), .LOCK_MASK(LOCK_MASK), .FAMILY(FAMILY)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .lock_set(lock_set),
  .ev_warm(ev_warm), .ev_cold(ev_cold), .ev_sx(ev_sx), .ev_global(ev_global),
  .ev_deep(ev_deep), .ev_g3(ev_g3), .cfg_q(cfg_q), .lock_q(lock_q),
  .rsv_q(rsv_q), .mismatch(mismatch)
);

// File: tb/pad_rst_domain_reg_tb.sv
module pad_rst_domain_reg_tb;
  import pad_rst_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          W    = 32;
  localparam logic [31:0] DEF  = 32'h4000_0000;
  localparam logic [31:0] MASK = 32'hC000_00FF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          lock_set = 1'b0;
  logic [5:0]    evs = '0; // {warm,cold,sx,global,deep,g3}

  logic [W-1:0] cfg_p, cfg_d;
  logic lock_p, lock_d, rsv_p, rsv_d, mis_p, mis_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_rst_domain_reg #(.CFG_W(W), .DEFAULT(DEF), .LOCK_MASK(MASK), .FAMILY(FAM_PRIMARY)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .lock_set(lock_set),
    .ev_warm(evs[5]), .ev_cold(evs[4]), .ev_sx(evs[3]), .ev_global(evs[2]),
    .ev_deep(evs[1]), .ev_g3(evs[0]),
    .cfg_q(cfg_p), .lock_q(lock_p), .rsv_q(rsv_p), .mismatch(mis_p));

  pad_rst_domain_reg #(.CFG_W(W), .DEFAULT(DEF), .LOCK_MASK(MASK), .FAMILY(FAM_DSW)) u_dut_dsw (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .lock_set(lock_set),
    .ev_warm(evs[5]), .ev_cold(evs[4]), .ev_sx(evs[3]), .ev_global(evs[2]),
    .ev_deep(evs[1]), .ev_g3(evs[0]),
    .cfg_q(cfg_d), .lock_q(lock_d), .rsv_q(rsv_d), .mismatch(mis_d));

  typedef struct {
    logic [W-1:0] cfg[2];
    logic         lock[2];
    logic         rsv[2];
    logic         mis[2];
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // reference model state, index 0 = primary-well, 1 = deep-sleep-well
  logic [W-1:0] m_cfg[2];
  logic         m_lock[2];
  logic         m_rsv[2];

  // which events reset code 'enc' in family f; order {warm,cold,sx,global,deep,g3}
  function automatic logic [5:0] row(int f, logic [1:0] enc);
    if (f == 0) begin
      case (enc)
        2'b00:   return 6'b000011;
        2'b01:   return 6'b110111;
        2'b10:   return 6'b111111;
        default: return 6'b000011;
      endcase
    end else begin
      case (enc)
        2'b00:   return 6'b000001;
        2'b01:   return 6'b110111;
        2'b10:   return 6'b111111;
        default: return 6'b000011;
      endcase
    end
  endfunction

  task automatic drive(input logic r, input logic we, input logic [W-1:0] d,
                       input logic ls, input logic [5:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; wr_en = we; wr_data = d; lock_set = ls; evs = e;
    @(posedge clk);
    #1;
    for (int f = 0; f < 2; f++) begin
      logic         ch, lh;
      logic [W-1:0] nv;
      ch = |(row(f, m_cfg[f][W-1:W-2]) & e);
      lh = |(row(f, 2'b00) & e);
      if (r) begin
        m_cfg[f] = DEF; m_rsv[f] = 1'b0; m_lock[f] = 1'b0;
      end else begin
        if (ch) begin
          m_cfg[f] = DEF; m_rsv[f] = 1'b0;
        end else if (we) begin
          nv = m_lock[f] ? ((m_cfg[f] & MASK) | (d & ~MASK)) : d;
          m_rsv[f] = 1'b0;
          if (f == 0 && nv[W-1:W-2] == 2'b11) begin
            nv[W-1:W-2] = 2'b00; m_rsv[f] = 1'b1;
          end
          m_cfg[f] = nv;
        end
        if (lh) m_lock[f] = 1'b0;
        else if (ls) m_lock[f] = 1'b1;
      end
      it.cfg[f]  = m_cfg[f];
      it.lock[f] = m_lock[f];
      it.rsv[f]  = m_rsv[f];
      it.mis[f]  = m_lock[f] && (m_cfg[f][W-1:W-2] != 2'b00);
    end
    it.tag = tag;
    sb_q.push_back(it);
    rst = 1'b0; wr_en = 1'b0; lock_set = 1'b0; evs = '0;
  endtask

  task automatic cmp(input string tag, input string who, input logic [W-1:0] ac, input logic [W-1:0] ec,
                     input logic al, input logic el, input logic ar, input logic er,
                     input logic am, input logic em);
    n_tests++;
    if (ac !== ec || al !== el || ar !== er || am !== em) begin
      n_fail++;
      $display("FAIL %s %s: cfg=%h lock=%b rsv=%b mis=%b expected cfg=%h lock=%b rsv=%b mis=%b",
               tag, who, ac, al, ar, am, ec, el, er, em);
    end
  endtask

  // monitor
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      cmp(it.tag, "primary", cfg_p, it.cfg[0], lock_p, it.lock[0], rsv_p, it.rsv[0], mis_p, it.mis[0]);
      cmp(it.tag, "dsw",     cfg_d, it.cfg[1], lock_d, it.lock[1], rsv_d, it.rsv[1], mis_d, it.mis[1]);
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 2; f++) begin
      m_cfg[f] = DEF; m_lock[f] = 1'b0; m_rsv[f] = 1'b0;
    end
    drive(1, 0, '0, 0, 6'b000000, "R1 reset state");
    drive(0, 1, 32'h8000_1234, 0, 6'b000000, "R2 write");
    drive(0, 0, '0, 0, 6'b001000, "R5 host code on sx");
    drive(0, 1, 32'h4000_5555, 0, 6'b000000, "R2 write deep code");
    drive(0, 0, '0, 0, 6'b001000, "R4 deep code keeps on sx");
    drive(0, 0, '0, 0, 6'b100000, "R4 deep code on warm");
    drive(0, 1, 32'h0000_0077, 0, 6'b000000, "R2 write pwrgood code");
    drive(0, 0, '0, 0, 6'b110100, "R3 pwrgood keeps on warm/cold/global");
    drive(0, 0, '0, 0, 6'b000010, "R3 pwrgood on deep-sleep");
    drive(0, 0, '0, 0, 6'b000001, "R3 pwrgood on G3");
    drive(0, 1, 32'hC000_0011, 0, 6'b000000, "R6 reserved code write");
    drive(0, 0, '0, 0, 6'b100000, "R6 code 11 keeps on warm");
    drive(0, 0, '0, 0, 6'b000010, "R6 code 11 on deep-sleep");
    drive(0, 1, 32'hC000_0011, 0, 6'b000000, "R6 reserved code again");
    drive(0, 1, 32'h8000_0000, 0, 6'b000000, "R6 clear flag by write");
    drive(0, 0, '0, 1, 6'b000000, "R7 lock set R10");
    drive(0, 1, 32'h0000_FFFF, 0, 6'b000000, "R8 locked write");
    drive(0, 0, '0, 0, 6'b100000, "R7 warm keeps lock R10");
    drive(0, 1, 32'h0000_0000, 0, 6'b000000, "R8 locked write code");
    drive(0, 1, 32'h8000_1111, 0, 6'b000100, "R9 write vs global");
    drive(0, 1, 32'h8000_2222, 0, 6'b000001, "R9 write vs G3");
    drive(0, 0, '0, 1, 6'b000000, "R7 relock");
    drive(0, 0, '0, 0, 6'b000010, "R7 deep-sleep clears primary lock");
    drive(0, 0, '0, 0, 6'b000001, "R7 G3 clears lock");
    drive(0, 0, '0, 1, 6'b000001, "R7 clear beats set");
    drive(0, 1, 32'h0000_0000, 0, 6'b000000, "R2 write pwrgood");
    drive(0, 0, '0, 1, 6'b000000, "R10 lock with pwrgood code");
    drive(1, 0, '0, 0, 6'b000000, "R1 reset clears lock");
    @(negedge clk);
    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule